// File: doc/BRIEF.md
# Snooping Palette DAC Emulator

This block sits beside a video palette DAC and listens to the host's writes to it. It never drives the host bus. From the writes it sees, it builds its own copy of the pixel mask, the 256-entry color palette and the 15-entry overlay palette. It then turns each pixel into an 18-bit digital RGB word for a flat panel, so the analog path is no longer needed.

Each pixel brings two indices. The first is an 8-bit color index, which is ANDed with the pixel mask. The second is a 4-bit overlay index. If the overlay index is non-zero, it selects an overlay entry and the color index is ignored. If it is zero, the masked color index selects a color entry. The output is registered, and it comes out a fixed two clocks after the pixel enters.

The host's strobe and data are taken to be already synchronous to `clk`, with each write lasting one cycle. The palette storage is not cleared at reset. An entry reads back a defined value only after it has been written.

Top module: `palette_snoop_dac`

## Requirements
- R1: On a cycle with `host_wr` high, `host_sel` decodes the write as follows. 0 loads the color write address from `host_data`. 3 loads the overlay write address from `host_data[3:0]`. 2 loads the pixel mask from `host_data`. 1 is a palette component write that uses `host_data[5:0]`.
- R2: Three component writes, in the order red, green, blue, commit one entry at the current write address. The commit goes to the palette named by the most recent address write.
- R3: Each committed entry advances the write address by one, and the component order restarts at red. The overlay address wraps within 4 bits.
- R4: Any address write restarts the component order at red. An unfinished triplet is dropped and is never committed.
- R5: The color index is ANDed with the pixel mask before the lookup. The mask is all ones after reset. The mask has no effect on overlay lookups.
- R6: An overlay index of 0 selects the color palette. An overlay index from 1 to 15 selects that overlay entry, whatever the color index is.
- R7: `rgb_valid` equals `pix_valid` from two clocks earlier. `rgb_out` holds the lookup for the pixel that entered two clocks earlier, and it reads 0 whenever `rgb_valid` is low.
- R8: `pal_loaded` rises on the clock edge that takes the blue write of overlay entry 15. It then stays high until reset.
- R9: `rgb_out[17:12]` carries red, `[11:6]` carries green and `[5:0]` carries blue.
- R10: After reset, `rgb_out` is 0, `rgb_valid` is 0 and `pal_loaded` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the host write lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle strobe for a snooped host write |
| host_sel | input | 2 | Register select of the snooped write |
| host_data | input | 8 | Snooped host data bus |
| pix_valid | input | 1 | Pixel indices are valid this cycle |
| pix_index | input | 8 | Color palette index |
| ovl_index | input | 4 | Overlay index; 0 means use the color palette |
| rgb_out | output | 18 | Registered RGB, 6 bits per component |
| rgb_valid | output | 1 | `rgb_out` carries a pixel |
| pal_loaded | output | 1 | The last overlay entry has been written |

## Verification
The bench builds the block with its default widths: an 8-bit color index, a 4-bit overlay index, 6-bit components and an 8-bit host bus. With these widths, one auto-incrementing run from overlay entry 1 fills all 15 overlay entries and drives the loaded flag. A mask of 0x0F folds color index 0x1A onto entry 10, so the mask can be observed at the output. Back-to-back pixels that mix color and overlay lookups exercise the two-cycle pipeline on every clock.

// File: rtl/psd_pkg.sv
// Package psd_pkg
// Shared encodings for the snooping palette DAC emulator.
// Assumes a 2-bit register select on the snooped host bus.
package psd_pkg;
    typedef enum logic [1:0] {
        SEL_CADDR = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_OADDR = 2'd3
    } sel_t;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;
endpackage

// File: rtl/psd_write_seq.sv
// Module psd_write_seq
// Decodes snooped host writes. It holds the pixel mask, the write address,
// the palette target and the red/green/blue gathering state, and it issues a
// registered commit for every completed triplet.
// Assumes host_wr is a one-cycle pulse synchronous to clk and DATA_W >= IDX_W.
module psd_write_seq
    import psd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 4,
    parameter int COMP_W = 6,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_data,
    output logic [IDX_W-1:0]  mask,
    output logic              cm_vld,
    output logic              cm_ovl,
    output logic [IDX_W-1:0]  cm_addr,
    output logic [RGB_W-1:0]  cm_rgb,
    output logic              loaded
);
    sel_t               sel_s;
    phase_t             phase;
    logic [IDX_W-1:0]   waddr;
    logic               tgt_ovl;
    logic [COMP_W-1:0]  hold_r;
    logic [COMP_W-1:0]  hold_g;
    logic [COMP_W-1:0]  comp_in;
    logic [OVL_W-1:0]   ovl_next;
    logic               ovl_last;

    // Decode the select lines and pick out the component field.
    always_comb begin
        sel_s    = sel_t'(host_sel);
        comp_in  = host_data[COMP_W-1:0];
        ovl_next = OVL_W'(waddr[OVL_W-1:0] + OVL_W'(1));
        ovl_last = (waddr[OVL_W-1:0] == {OVL_W{1'b1}});
    end

    // Register updates driven by the snooped writes, plus the commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '1;
            waddr   <= '0;
            tgt_ovl <= 1'b0;
            phase   <= PH_RED;
            hold_r  <= '0;
            hold_g  <= '0;
            cm_vld  <= 1'b0;
            cm_ovl  <= 1'b0;
            cm_addr <= '0;
            cm_rgb  <= '0;
            loaded  <= 1'b0;
        end else begin
            cm_vld <= 1'b0;
            if (host_wr) begin
                case (sel_s)
                    SEL_CADDR: begin
                        waddr   <= host_data[IDX_W-1:0];
                        tgt_ovl <= 1'b0;
                        phase   <= PH_RED;
                    end
                    SEL_OADDR: begin
                        waddr   <= IDX_W'(host_data[OVL_W-1:0]);
                        tgt_ovl <= 1'b1;
                        phase   <= PH_RED;
                    end
                    SEL_MASK: begin
                        mask <= host_data[IDX_W-1:0];
                    end
                    default: begin
                        case (phase)
                            PH_RED: begin
                                hold_r <= comp_in;
                                phase  <= PH_GRN;
                            end
                            PH_GRN: begin
                                hold_g <= comp_in;
                                phase  <= PH_BLU;
                            end
                            PH_BLU: begin
                                cm_vld  <= 1'b1;
                                cm_ovl  <= tgt_ovl;
                                cm_addr <= waddr;
                                cm_rgb  <= {hold_r, hold_g, comp_in};
                                phase   <= PH_RED;
                                if (tgt_ovl) begin
                                    waddr <= IDX_W'(ovl_next);
                                    if (ovl_last) loaded <= 1'b1;
                                end else begin
                                    waddr <= waddr + IDX_W'(1);
                                end
                            end
                            default: phase <= PH_RED;
                        endcase
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/psd_color_ram.sv
// Module psd_color_ram
// Color palette storage with one array per primary color. It has a single
// write port and an asynchronous read port.
// Assumes the contents need no reset; an entry is defined once written.
module psd_color_ram #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    localparam int DEPTH = 1 << IDX_W,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata
);
    for (genvar c = 0; c < 3; c++) begin : g_comp
        logic [COMP_W-1:0] mem [DEPTH];

        // Store this component on a commit.
        always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata[c*COMP_W +: COMP_W];
        end

        assign rdata[c*COMP_W +: COMP_W] = mem[raddr];
    end
endmodule

// File: rtl/psd_overlay_ram.sv
// Module psd_overlay_ram
// Overlay palette storage. Entries 1 .. 2**OVL_W-1 are usable. Index 0 means
// "no overlay", so writes to it are dropped.
// Assumes the reader never selects index 0 from this store.
module psd_overlay_ram #(
    parameter int OVL_W  = 4,
    parameter int COMP_W = 6,
    localparam int DEPTH = 1 << OVL_W,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [OVL_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [OVL_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata
);
    logic [RGB_W-1:0] mem [DEPTH];

    // Store an overlay entry unless it targets the reserved index.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/psd_pixel_pipe.sv
// Module psd_pixel_pipe
// Two-stage pixel path. Stage one registers the masked color index, the
// overlay index and the valid flag. Stage two selects between the two
// palettes and registers the RGB word.
// Assumes the palette read ports are asynchronous.
module psd_pixel_pipe #(
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 4,
    parameter int COMP_W = 6,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] pix_index,
    input  logic [OVL_W-1:0] ovl_index,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] c_raddr,
    output logic [OVL_W-1:0] o_raddr,
    input  logic [RGB_W-1:0] c_rdata,
    input  logic [RGB_W-1:0] o_rdata,
    output logic [RGB_W-1:0] rgb_out,
    output logic             rgb_valid
);
    logic [IDX_W-1:0] idx_q;
    logic [OVL_W-1:0] ovl_q;
    logic             vld_q;

    // Stage one: capture the masked index, the overlay index and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ovl_q <= '0;
            vld_q <= 1'b0;
        end else begin
            idx_q <= pix_index & mask;
            ovl_q <= ovl_index;
            vld_q <= pix_valid;
        end
    end

    assign c_raddr = idx_q;
    assign o_raddr = ovl_q;

    // Stage two: choose the palette and register the result, or zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out   <= '0;
            rgb_valid <= 1'b0;
        end else begin
            rgb_valid <= vld_q;
            if (!vld_q)            rgb_out <= '0;
            else if (ovl_q != '0)  rgb_out <= o_rdata;
            else                   rgb_out <= c_rdata;
        end
    end
endmodule

// File: rtl/palette_snoop_dac.sv
// Module palette_snoop_dac
// Top level. It rebuilds a palette DAC's contents from snooped host writes
// and converts pixel or overlay indices into registered digital RGB.
// Assumes the host bus is synchronous to clk; the output latency is two clocks.
module palette_snoop_dac #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 4,
    parameter int COMP_W = 6,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_data,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_index,
    input  logic [OVL_W-1:0]  ovl_index,
    output logic [RGB_W-1:0]  rgb_out,
    output logic              rgb_valid,
    output logic              pal_loaded
);
    logic [IDX_W-1:0] mask;
    logic             cm_vld;
    logic             cm_ovl;
    logic [IDX_W-1:0] cm_addr;
    logic [RGB_W-1:0] cm_rgb;
    logic [IDX_W-1:0] c_raddr;
    logic [OVL_W-1:0] o_raddr;
    logic [RGB_W-1:0] c_rdata;
    logic [RGB_W-1:0] o_rdata;
    logic             c_we;
    logic             o_we;

    // Route each commit to the palette it targets.
    always_comb begin
        c_we = cm_vld && !cm_ovl;
        o_we = cm_vld &&  cm_ovl;
    end

    psd_write_seq #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .OVL_W(OVL_W), .COMP_W(COMP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_sel(host_sel), .host_data(host_data),
        .mask(mask), .cm_vld(cm_vld), .cm_ovl(cm_ovl),
        .cm_addr(cm_addr), .cm_rgb(cm_rgb), .loaded(pal_loaded)
    );

    psd_color_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_cram (
        .clk(clk), .we(c_we), .waddr(cm_addr), .wdata(cm_rgb),
        .raddr(c_raddr), .rdata(c_rdata)
    );

    psd_overlay_ram #(.OVL_W(OVL_W), .COMP_W(COMP_W)) u_oram (
        .clk(clk), .we(o_we), .waddr(cm_addr[OVL_W-1:0]), .wdata(cm_rgb),
        .raddr(o_raddr), .rdata(o_rdata)
    );

    psd_pixel_pipe #(.IDX_W(IDX_W), .OVL_W(OVL_W), .COMP_W(COMP_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_index(pix_index), .ovl_index(ovl_index),
        .mask(mask), .c_raddr(c_raddr), .o_raddr(o_raddr),
        .c_rdata(c_rdata), .o_rdata(o_rdata),
        .rgb_out(rgb_out), .rgb_valid(rgb_valid)
    );
endmodule

// File: rtl/psd_checker.sv
// Module psd_checker
// Port-level properties of palette_snoop_dac. It is bound to every instance.
// Assumes synchronous active-low reset; a small counter gates the checks
// that look two cycles back.
module psd_checker #(
    parameter int RGB_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_sel,
    input logic             pix_valid,
    input logic [RGB_W-1:0] rgb_out,
    input logic             rgb_valid,
    input logic             pal_loaded
);
    logic [1:0] cyc;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (rgb_valid == $past(pix_valid, 2)));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_valid |-> (rgb_out == '0));

    a_r8_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pal_loaded |=> pal_loaded);

    // R8: the flag can only rise from a palette component write (select 1).
    a_r8_loaded_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pal_loaded) |-> $past(host_wr && (host_sel == 2'd1)));
endmodule

bind palette_snoop_dac psd_checker #(.RGB_W(3 * COMP_W)) u_chk (.*);

// File: tb/test_palette_snoop_dac.sv
`timescale 1ns/1ps
module test_palette_snoop_dac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_data = 8'd0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = 8'd0;
    logic [3:0]  ovl_index = 4'd0;
    logic [17:0] rgb_out;
    logic        rgb_valid;
    logic        pal_loaded;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    palette_snoop_dac i_palette_snoop_dac (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_data(host_data), .pix_valid(pix_valid), .pix_index(pix_index),
        .ovl_index(ovl_index), .rgb_out(rgb_out), .rgb_valid(rgb_valid),
        .pal_loaded(pal_loaded)
    );

    function automatic logic [17:0] pk(input logic [5:0] r, input logic [5:0] g,
                                       input logic [5:0] b);
        return {r, g, b};
    endfunction

    function automatic logic [17:0] ovl_col(input int k);
        return pk(6'(k), 6'(k + 16), 6'(k + 32));
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic put_rgb(input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
        hw(2'd1, {2'b00, r}); hw(2'd1, {2'b00, g}); hw(2'd1, {2'b00, b});
    endtask

    // One pixel in, checked through the latency window and the idle cycle after it.
    task automatic probe(input string req, input logic [7:0] idx, input logic [3:0] ovl,
                         input logic [17:0] exp);
        @(negedge clk);
        pix_valid = 1'b1; pix_index = idx; ovl_index = ovl;
        @(negedge clk);
        pix_valid = 1'b0;
        chk({req, " R7 early"}, {17'd0, rgb_valid}, 18'd0);
        @(negedge clk);
        chk({req, " R7 valid"}, {17'd0, rgb_valid}, 18'd1);
        chk(req, rgb_out, exp);
        @(negedge clk);
        chk({req, " R7 idle"}, {rgb_out[16:0], rgb_valid}, 18'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 rgb_out", rgb_out, 18'd0);
        chk("R10 valid/loaded", {16'd0, rgb_valid, pal_loaded}, 18'd0);
    endtask

    task automatic t_basic;
        hw(2'd0, 8'd5);
        put_rgb(6'h11, 6'h22, 6'h33);
        probe("R1 R2 R9 R5-default-mask color5", 8'd5, 4'd0, pk(6'h11, 6'h22, 6'h33));
    endtask

    task automatic t_autoinc;
        hw(2'd0, 8'd10);
        put_rgb(6'h0A, 6'h1B, 6'h2C);
        put_rgb(6'h3D, 6'h01, 6'h12);
        probe("R3 entry10", 8'd10, 4'd0, pk(6'h0A, 6'h1B, 6'h2C));
        probe("R3 entry11", 8'd11, 4'd0, pk(6'h3D, 6'h01, 6'h12));
    endtask

    task automatic t_restart;
        hw(2'd0, 8'd20);
        hw(2'd1, 8'h3F); hw(2'd1, 8'h3E);
        hw(2'd0, 8'd20);
        put_rgb(6'h05, 6'h06, 6'h07);
        probe("R4 restart", 8'd20, 4'd0, pk(6'h05, 6'h06, 6'h07));
    endtask

    task automatic t_overlay;
        hw(2'd3, 8'd1);
        for (int k = 1; k <= 14; k++) put_rgb(6'(k), 6'(k + 16), 6'(k + 32));
        chk("R8 not loaded before 15", {17'd0, pal_loaded}, 18'd0);
        put_rgb(6'd15, 6'd31, 6'd47);
        chk("R8 loaded after 15", {17'd0, pal_loaded}, 18'd1);
        probe("R6 overlay3", 8'd5, 4'd3, ovl_col(3));
        probe("R6 overlay15", 8'd10, 4'd15, ovl_col(15));
        probe("R6 overlay0 uses color", 8'd5, 4'd0, pk(6'h11, 6'h22, 6'h33));
    endtask

    task automatic t_mask;
        hw(2'd2, 8'h0F);
        probe("R5 mask 1A->10", 8'h1A, 4'd0, pk(6'h0A, 6'h1B, 6'h2C));
        probe("R5 mask 15->5", 8'h15, 4'd0, pk(6'h11, 6'h22, 6'h33));
        probe("R5 mask no effect on overlay", 8'h1A, 4'd2, ovl_col(2));
        chk("R8 stays high", {17'd0, pal_loaded}, 18'd1);
        hw(2'd2, 8'hFF);
    endtask

    task automatic t_stream;
        logic [7:0]  si [4];
        logic [3:0]  so [4];
        logic [17:0] se [4];
        si[0] = 8'd5;  so[0] = 4'd0; se[0] = pk(6'h11, 6'h22, 6'h33);
        si[1] = 8'd10; so[1] = 4'd0; se[1] = pk(6'h0A, 6'h1B, 6'h2C);
        si[2] = 8'd0;  so[2] = 4'd7; se[2] = ovl_col(7);
        si[3] = 8'd11; so[3] = 4'd0; se[3] = pk(6'h3D, 6'h01, 6'h12);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R7 stream valid", {17'd0, rgb_valid}, 18'd1);
                chk("R7 stream data", rgb_out, se[k-2]);
            end
            if (k < 4) begin
                pix_valid = 1'b1; pix_index = si[k]; ovl_index = so[k];
            end else begin
                pix_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R7 stream end", {rgb_out[16:0], rgb_valid}, 18'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_autoinc();
        t_restart();
        t_overlay();
        t_mask();
        t_stream();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule